// File: doc/BRIEF.md
# Receive Flow-Control Pause Detector with Transmit Holdoff

This block watches the receive side of a gigabit Ethernet port. Each frame arrives as a stream of 16-bit words with start and end markers. The block looks for MAC Control frames that ask the link partner to stop sending. When it finds a valid one, it takes the 16-bit pause time carried in the frame and holds the local transmitter off for that long. The time is counted in quanta of 512 bit times, which is 64 cycles of a 125 MHz byte-wide datapath.

The frame is accepted only when the CRC-good flag is high on its last word. An accepted frame reloads the holdoff timer, whatever count is still running. A pause time of zero ends the holdoff at once. The transmit-enable output changes only while the local transmitter is idle, so a frame already on the wire is never cut short. Each accepted frame gives a one-cycle detect pulse, and the pause time that was applied stays on a status output.

Top module: `pause_holdoff`

## Requirements
- R1: A frame qualifies only if its words 0, 1 and 2 (counted from the word marked start-of-frame) are 0x0180, 0xC200 and 0x0001.
- R2: A frame qualifies only if word 6 (the length/type word, after the 6-byte source address in words 3..5) is 0x8808.
- R3: A frame qualifies only if word 7 (the control opcode) is 0x0001.
- R4: The pause time is taken from word 8. A frame whose end marker comes before word 8 is ignored.
- R5: A qualifying frame is applied only if `rx_crc_good` is high in the cycle of its end-marked word. Otherwise it has no effect on any output.
- R6: One cycle after the end-marked word of an applied frame, `pause_seen` is high for exactly one cycle. In that same cycle `pause_quanta` shows the frame's pause time and keeps it until the next applied frame.
- R7: With `tx_busy` low, `tx_enable` goes low two cycles after `pause_seen` rises. It stays low for exactly Q×CYCLES_PER_QUANTA cycles, where Q is the pause time.
- R8: An applied frame reloads the holdoff with its own pause time and discards any count still remaining.
- R9: An applied pause time of zero raises `tx_enable` two cycles after `pause_seen`, even when a long holdoff is running.
- R10: While `tx_busy` is high, `tx_enable` keeps its value. A pending change takes effect in the cycle after `tx_busy` falls.
- R11: After reset, `tx_enable` is 1, `pause_seen` is 0 and `pause_quanta` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive word valid |
| rx_sof | input | 1 | Word is the first of a frame |
| rx_eof | input | 1 | Word is the last of a frame |
| rx_word | input | 16 | Receive data word |
| rx_crc_good | input | 1 | CRC status, meaningful with the end-marked word |
| tx_busy | input | 1 | Local transmitter is sending a frame |
| tx_enable | output | 1 | Permission for the local transmitter to start a frame |
| pause_seen | output | 1 | One-cycle pulse for each applied pause frame |
| pause_quanta | output | 16 | Pause time of the last applied frame |

## Verification
The bench builds the block with CYCLES_PER_QUANTA set to 2. At that setting whole holdoff periods fit in a short run, and the exact length of a low pulse on `tx_enable` can be counted clock by clock. Even a 0xFFFF request lasts only about 131k cycles. The bench cancels it with a zero-time frame after a few thousand cycles, which covers both the maximum request and the early release. Short frames, frames that mismatch in each checked field, a bad CRC, a reload during a running holdoff and a pause that arrives while the transmitter is busy each come in their own phase.

// File: rtl/pause_holdoff_pkg.sv
package pause_holdoff_pkg;
  localparam int WORD_W = 16;
  localparam int QW     = 16;
  localparam logic [WORD_W-1:0] DA_W0   = 16'h0180;
  localparam logic [WORD_W-1:0] DA_W1   = 16'hC200;
  localparam logic [WORD_W-1:0] DA_W2   = 16'h0001;
  localparam logic [WORD_W-1:0] CTL_TYPE = 16'h8808;
  localparam logic [WORD_W-1:0] OPC_PAUSE = 16'h0001;
  localparam int POS_TYPE   = 6;
  localparam int POS_OPC    = 7;
  localparam int POS_QUANTA = 8;
  localparam int IDX_W      = 4;
endpackage

// File: rtl/pause_frame_parser.sv
module pause_frame_parser
  import pause_holdoff_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              rx_crc_good,
  output logic              apply_o,
  output logic [QW-1:0]     quanta_o
);
  localparam logic [IDX_W-1:0] IDX_SAT = IDX_W'(POS_QUANTA + 1);

  logic             in_frame;
  logic [IDX_W-1:0] idx;
  logic             good;
  logic [QW-1:0]    qcap;

  logic [IDX_W-1:0] idx_now;
  logic             word_ok, good_now, active, accept;
  logic [QW-1:0]    q_now;

  always_comb begin
    idx_now = rx_sof ? '0 : idx;
    case (idx_now)
      IDX_W'(0):          word_ok = (rx_word == DA_W0);
      IDX_W'(1):          word_ok = (rx_word == DA_W1);
      IDX_W'(2):          word_ok = (rx_word == DA_W2);
      IDX_W'(POS_TYPE):   word_ok = (rx_word == CTL_TYPE);
      IDX_W'(POS_OPC):    word_ok = (rx_word == OPC_PAUSE);
      default:            word_ok = 1'b1;
    endcase
    good_now = (rx_sof ? 1'b1 : good) && word_ok;
    active   = rx_valid && (rx_sof || in_frame);
    q_now    = (idx_now == IDX_W'(POS_QUANTA)) ? rx_word[QW-1:0] : qcap;
    accept   = active && rx_eof && good_now && rx_crc_good &&
               (idx_now >= IDX_W'(POS_QUANTA));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      idx      <= '0;
      good     <= 1'b0;
      qcap     <= '0;
      apply_o  <= 1'b0;
      quanta_o <= '0;
    end else begin
      apply_o <= accept;
      if (accept) quanta_o <= q_now;
      if (active) begin
        if (rx_eof) begin
          in_frame <= 1'b0;
        end else begin
          in_frame <= 1'b1;
          idx      <= (idx_now == IDX_SAT) ? IDX_SAT : idx_now + 1'b1;
          good     <= good_now;
          qcap     <= q_now;
        end
      end
    end
  end

  // R5
  bad_crc_no_apply_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_eof && !rx_crc_good) |=> !apply_o);
  // R6
  apply_single_chk: assert property (@(posedge clk) disable iff (rst)
    apply_o |=> !apply_o);
endmodule

// File: rtl/holdoff_timer.sv
module holdoff_timer
  import pause_holdoff_pkg::*;
#(
  parameter int CYCLES_PER_QUANTA = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [QW-1:0] quanta_i,
  output logic          hold_o
);
  localparam int SUB_W = (CYCLES_PER_QUANTA > 1) ? $clog2(CYCLES_PER_QUANTA) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CYCLES_PER_QUANTA - 1);

  logic [QW-1:0]    remaining;
  logic [SUB_W-1:0] sub;

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
      sub       <= '0;
    end else if (load_i) begin
      remaining <= quanta_i;
      sub       <= '0;
    end else if (remaining != '0) begin
      if (sub == SUB_LAST) begin
        sub       <= '0;
        remaining <= remaining - 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  assign hold_o = (remaining != '0);

  // R7
  load_nonzero_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && quanta_i != '0) |=> hold_o);
  // R9
  load_zero_releases_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && quanta_i == '0) |=> !hold_o);
  // R8
  count_never_rises_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> remaining <= $past(remaining));
endmodule

// File: rtl/tx_gate.sv
module tx_gate (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  input  logic tx_busy_i,
  output logic tx_enable_o
);
  always_ff @(posedge clk) begin
    if (rst) tx_enable_o <= 1'b1;
    else if (!tx_busy_i) tx_enable_o <= !hold_i;
  end
endmodule

// File: rtl/pause_holdoff.sv
module pause_holdoff
  import pause_holdoff_pkg::*;
#(
  parameter int CYCLES_PER_QUANTA = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [15:0] rx_word,
  input  logic        rx_crc_good,
  input  logic        tx_busy,
  output logic        tx_enable,
  output logic        pause_seen,
  output logic [15:0] pause_quanta
);
  logic hold;

  pause_frame_parser u_parser (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_word(rx_word), .rx_crc_good(rx_crc_good),
    .apply_o(pause_seen), .quanta_o(pause_quanta)
  );

  holdoff_timer #(.CYCLES_PER_QUANTA(CYCLES_PER_QUANTA)) u_timer (
    .clk(clk), .rst(rst), .load_i(pause_seen), .quanta_i(pause_quanta),
    .hold_o(hold)
  );

  tx_gate u_gate (
    .clk(clk), .rst(rst), .hold_i(hold), .tx_busy_i(tx_busy),
    .tx_enable_o(tx_enable)
  );

  // R10
  tx_enable_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(tx_busy) && !$past(rst)) |-> $stable(tx_enable));
endmodule

// File: tb/pause_holdoff_bench.sv
module pause_holdoff_bench;
  localparam int CPQ = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_crc_good = 0, tx_busy = 0;
  logic [15:0] rx_word = '0;
  logic tx_enable, pause_seen;
  logic [15:0] pause_quanta;

  int checks = 0, fails = 0;
  string cur_req = "R11";

  always #4 clk = ~clk;

  pause_holdoff #(.CYCLES_PER_QUANTA(CPQ)) u_pause_holdoff (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_word(rx_word), .rx_crc_good(rx_crc_good),
    .tx_busy(tx_busy), .tx_enable(tx_enable), .pause_seen(pause_seen),
    .pause_quanta(pause_quanta)
  );

  // behavioural reference model
  bit m_en = 1, m_pulse = 0;
  int m_qout = 0, m_cnt = 0;
  int widx = 0, fq = 0;
  bit infr = 0, fgood = 0;
  int lowlen = 0, last_low = -1;

  always @(posedge clk) begin
    bit old_pulse, old_hold;
    int old_q;
    if (rst) begin
      m_en = 1; m_pulse = 0; m_qout = 0; m_cnt = 0; infr = 0;
    end else begin
      old_pulse = m_pulse; old_q = m_qout; old_hold = (m_cnt > 0);
      if (!tx_busy) m_en = !old_hold;
      if (old_pulse) m_cnt = old_q * CPQ;
      else if (m_cnt > 0) m_cnt--;
      m_pulse = 0;
      if (rx_valid && (rx_sof || infr)) begin
        if (rx_sof) begin widx = 0; fgood = 1; end
        case (widx)
          0: fgood &= (rx_word == 16'h0180);
          1: fgood &= (rx_word == 16'hC200);
          2: fgood &= (rx_word == 16'h0001);
          6: fgood &= (rx_word == 16'h8808);
          7: fgood &= (rx_word == 16'h0001);
          8: fq = rx_word;
          default: ;
        endcase
        if (rx_eof) begin
          if (fgood && widx >= 8 && rx_crc_good) begin
            m_pulse = 1; m_qout = fq;
          end
          infr = 0;
        end else infr = 1;
        widx++;
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("tx_enable", tx_enable, m_en);
      chk("pause_seen", pause_seen, m_pulse);
      chk("pause_quanta", pause_quanta, m_qout);
      if (!tx_enable) lowlen++;
      else if (lowlen != 0) begin last_low = lowlen; lowlen = 0; end
    end
  end

  function automatic logic [15:0] fw(int i, logic [15:0] d0, logic [15:0] ty,
                                     logic [15:0] op, logic [15:0] q);
    case (i)
      0: return d0;
      1: return 16'hC200;
      2: return 16'h0001;
      3: return 16'h0012;
      4: return 16'h3456;
      5: return 16'h789A;
      6: return ty;
      7: return op;
      8: return q;
      default: return 16'(i * 16'h1111);
    endcase
  endfunction

  task automatic send(input logic [15:0] d0, input logic [15:0] ty,
                      input logic [15:0] op, input logic [15:0] q,
                      input int nw, input bit crc);
    for (int i = 0; i < nw; i++) begin
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == nw - 1);
      rx_word = fw(i, d0, ty, op, q); rx_crc_good = crc;
      @(negedge clk);
    end
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_crc_good = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R11";
    chk("reset tx_enable", tx_enable, 1);
    chk("reset quanta", pause_quanta, 0);
    // R1 R2 R3 R5 R6 R7: basic pause, hold length measured
    cur_req = "R7";
    send(16'h0180, 16'h8808, 16'h0001, 16'd3, 30, 1);
    idle(20);
    chk("R7 low length", last_low, 3 * CPQ);
    cur_req = "R1"; send(16'h0181, 16'h8808, 16'h0001, 16'd5, 30, 1); idle(10);
    chk("R1 no hold", tx_enable, 1);
    cur_req = "R2"; send(16'h0180, 16'h0800, 16'h0001, 16'd5, 30, 1); idle(10);
    chk("R2 no hold", tx_enable, 1);
    cur_req = "R3"; send(16'h0180, 16'h8808, 16'h0002, 16'd5, 30, 1); idle(10);
    chk("R3 no hold", tx_enable, 1);
    cur_req = "R5"; send(16'h0180, 16'h8808, 16'h0001, 16'd5, 30, 0); idle(10);
    chk("R5 quanta kept", pause_quanta, 3);
    cur_req = "R4"; send(16'h0180, 16'h8808, 16'h0001, 16'd5, 8, 1); idle(10);
    chk("R4 quanta kept", pause_quanta, 3);
    cur_req = "R4"; send(16'h0180, 16'h8808, 16'h0001, 16'd4, 9, 1); idle(20);
    chk("R4 minimal frame length", last_low, 4 * CPQ);
    cur_req = "R6"; send(16'h0180, 16'h8808, 16'h0001, 16'h0007, 12, 1); idle(30);
    chk("R6 quanta held", pause_quanta, 7);
    // R8 reload
    cur_req = "R8";
    send(16'h0180, 16'h8808, 16'h0001, 16'd40, 10, 1); idle(5);
    send(16'h0180, 16'h8808, 16'h0001, 16'd2, 10, 1); idle(20);
    chk("R8 reloaded", tx_enable, 1);
    // R10 busy freezes
    cur_req = "R10";
    tx_busy = 1;
    send(16'h0180, 16'h8808, 16'h0001, 16'd20, 10, 1); idle(6);
    chk("R10 frozen", tx_enable, 1);
    tx_busy = 0; idle(2);
    chk("R10 released", tx_enable, 0);
    idle(60);
    // R9 max then cancel
    cur_req = "R9";
    send(16'h0180, 16'h8808, 16'h0001, 16'hFFFF, 10, 1); idle(3000);
    chk("R9 max still holding", tx_enable, 0);
    send(16'h0180, 16'h8808, 16'h0001, 16'h0000, 10, 1); idle(3);
    chk("R9 cancelled", tx_enable, 1);
    idle(10);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule